// File: doc/BRIEF.md
# Method Address and Emit Unit

This block tracks where a small macro engine's command writes go. A set-address value loads a method word index and a per-write stride. Each accepted emit data word then leaves the block as one (byte address, data) write on a strobed output port. After every emit the address steps forward by the stride, counted in 32-bit words. Emits that arrive before any address has been set are dropped without output.

Two sinks inside the block watch the same emitted writes. The first is a staged semaphore. Three writes load an upper address half, a lower address half and a payload. A fourth write, carrying a fixed key word, releases a 32-bit memory write of the payload to the 64-bit address built from the two halves. The second sink is a window of scratch registers. Emits into the window store data, and a combinational read port returns the stored value, or zero outside the window.

Top module: `method_emit_unit`

## Requirements
- R1: On `set_valid`, `set_value[11:0]` is a word index and the method byte address becomes that index shifted left by 2. Bits 31:16 of `set_value` are ignored.
- R2: On `set_valid`, `set_value[15:12]` is latched as the stride. After each accepted emit the byte address grows by stride×4, so a stride of 0 repeats the same address.
- R3: The byte address is 16 bits wide and wraps modulo 65536 when it is stepped.
- R4: Emits produce no output until an address has been set. Synchronous reset (`rst` high) clears the "address set" flag.
- R5: An accepted emit in cycle n gives `out_valid` high for exactly cycle n+1, with `out_addr` equal to the address in use and `out_data` equal to `emit_data`.
- R6: When `set_valid` and `emit_valid` are high in the same cycle, the emit uses the newly set address and stride.
- R7: Emits to `SEM_BASE`, `SEM_BASE+4` and `SEM_BASE+8` store the upper address, lower address and payload. An emit to `SEM_BASE+12` with data equal to `RELEASE_KEY` (default 0x10000000) pulses `mem_valid` in the next cycle, with `mem_addr` = {upper, lower} and `mem_data` = payload.
- R8: An emit to `SEM_BASE+12` with any data other than `RELEASE_KEY` gives no `mem_valid`.
- R9: An emit to `SCR_BASE+4*i` with i < `SCR_COUNT` stores the data in scratch register i. `rd_data` returns scratch i when `rd_addr` = `SCR_BASE+4*i`, and 0 for any other address.
- R10: After reset, `out_valid`, `mem_valid` and every scratch register are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| set_valid | input | 1 | Load address and stride from set_value |
| set_value | input | 32 | Bits 11:0 word index, bits 15:12 stride |
| emit_valid | input | 1 | Emit one data word |
| emit_data | input | 32 | Data word to emit |
| out_valid | output | 1 | One-cycle write strobe |
| out_addr | output | 16 | Method byte address of the write |
| out_data | output | 32 | Data of the write |
| mem_valid | output | 1 | One-cycle semaphore memory write strobe |
| mem_addr | output | 64 | Semaphore target address |
| mem_data | output | 32 | Semaphore payload |
| rd_addr | input | 16 | Scratch read byte address |
| rd_data | output | 32 | Scratch read data, 0 outside the window |

## Verification
The hardest case to reach is the 16-bit address wrap. Set-address values can only reach byte address 0x3FFC, so the address has to be walked across the top of the space by emits alone. The stimulus sets index 0xFFF with the largest stride and issues about 900 emits. The bench compares every output address with a modulo-65536 running sum, which steps the address past 0xFFFF.

Stride coverage is a sweep over all sixteen strides at several start indices. The release key is checked in both its accepted and rejected forms.

// File: rtl/method_emit_unit.sv
module method_emit_unit #(
  parameter logic [15:0] SEM_BASE    = 16'h1B00,
  parameter logic [15:0] SCR_BASE    = 16'h3400,
  parameter int          SCR_COUNT   = 8,
  parameter logic [31:0] RELEASE_KEY = 32'h1000_0000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        set_valid,
  input  logic [31:0] set_value,
  input  logic        emit_valid,
  input  logic [31:0] emit_data,
  output logic        out_valid,
  output logic [15:0] out_addr,
  output logic [31:0] out_data,
  output logic        mem_valid,
  output logic [63:0] mem_addr,
  output logic [31:0] mem_data,
  input  logic [15:0] rd_addr,
  output logic [31:0] rd_data
);

  localparam logic [15:0] SEM_LO  = SEM_BASE + 16'd4;
  localparam logic [15:0] SEM_PAY = SEM_BASE + 16'd8;
  localparam logic [15:0] SEM_GO  = SEM_BASE + 16'd12;

  logic [15:0] addr_q;
  logic [3:0]  inc_q;
  logic        have_q;
  logic [31:0] sem_hi, sem_lo, sem_pay;
  logic [31:0] scr [SCR_COUNT];

  wire [15:0] cur_addr = set_valid ? {2'b00, set_value[11:0], 2'b00} : addr_q;
  wire [3:0]  cur_inc  = set_valid ? set_value[15:12] : inc_q;
  wire        fire     = emit_valid && (set_valid || have_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q    <= '0;
      inc_q     <= '0;
      have_q    <= 1'b0;
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_data  <= '0;
    end else begin
      if (set_valid) begin
        addr_q <= cur_addr;
        inc_q  <= cur_inc;
        have_q <= 1'b1;
      end
      if (fire) addr_q <= cur_addr + {10'd0, cur_inc, 2'b00};
      out_valid <= fire;
      if (fire) begin
        out_addr <= cur_addr;
        out_data <= emit_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sem_hi    <= '0;
      sem_lo    <= '0;
      sem_pay   <= '0;
      mem_valid <= 1'b0;
      mem_addr  <= '0;
      mem_data  <= '0;
    end else begin
      mem_valid <= 1'b0;
      if (fire) begin
        if (cur_addr == SEM_BASE) sem_hi  <= emit_data;
        if (cur_addr == SEM_LO)   sem_lo  <= emit_data;
        if (cur_addr == SEM_PAY)  sem_pay <= emit_data;
        if (cur_addr == SEM_GO && emit_data == RELEASE_KEY) begin
          mem_valid <= 1'b1;
          mem_addr  <= {sem_hi, sem_lo};
          mem_data  <= sem_pay;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < SCR_COUNT; i++) begin
      if (rst) scr[i] <= '0;
      else if (fire && cur_addr == SCR_BASE + 16'(4 * i)) scr[i] <= emit_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < SCR_COUNT; i++)
      if (rd_addr == SCR_BASE + 16'(4 * i)) rd_data = scr[i];
  end

  p_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(emit_valid));

  p_drop_r4: assert property (@(posedge clk) disable iff (rst)
    (emit_valid && !set_valid && !have_q) |=> !out_valid);

  p_flag_r4: assert property (@(posedge clk) disable iff (rst)
    have_q |=> have_q);

  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (emit_valid && have_q && !set_valid) |=> (out_valid && out_addr == $past(addr_q)));

  p_same_r6: assert property (@(posedge clk) disable iff (rst)
    (emit_valid && set_valid) |=> (out_addr == {2'b00, $past(set_value[11:0]), 2'b00}));

  p_key_r7: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> ($past(emit_valid) && $past(emit_data) == RELEASE_KEY));

endmodule

// File: tb/method_emit_unit_test.sv
module method_emit_unit_test;
  localparam logic [15:0] SEM_BASE = 16'h1B00;
  localparam logic [15:0] SCR_BASE = 16'h3400;
  localparam int          SCR_COUNT = 8;
  localparam logic [31:0] KEY = 32'h1000_0000;

  logic clk = 0, rst = 1;
  logic set_valid = 0, emit_valid = 0;
  logic [31:0] set_value = 0, emit_data = 0;
  logic [15:0] rd_addr = 0;
  logic out_valid, mem_valid;
  logic [15:0] out_addr;
  logic [31:0] out_data, mem_data, rd_data;
  logic [63:0] mem_addr;

  int checks = 0, failures = 0;

  method_emit_unit #(.SEM_BASE(SEM_BASE), .SCR_BASE(SCR_BASE), .SCR_COUNT(SCR_COUNT),
                     .RELEASE_KEY(KEY)) uut (
    .clk(clk), .rst(rst), .set_valid(set_valid), .set_value(set_value),
    .emit_valid(emit_valid), .emit_data(emit_data), .out_valid(out_valid),
    .out_addr(out_addr), .out_data(out_data), .mem_valid(mem_valid),
    .mem_addr(mem_addr), .mem_data(mem_data), .rd_addr(rd_addr), .rd_data(rd_data));

  always #4 clk = ~clk;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(bit sv, logic [31:0] sval, bit ev, logic [31:0] ed);
    @(negedge clk);
    set_valid = sv; set_value = sval; emit_valid = ev; emit_data = ed;
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; set_valid = 0; emit_valid = 0;
    @(posedge clk); @(posedge clk); #1;
    @(negedge clk); rst = 0;
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] model;
    do_reset();
    // R10 reset state
    chk("R10 out_valid", out_valid, 0);
    chk("R10 mem_valid", mem_valid, 0);
    for (int i = 0; i < SCR_COUNT; i++) begin
      rd_addr = SCR_BASE + 16'(4*i); #1;
      chk("R10 scratch", rd_data, 0);
    end
    // R4 emits before any set are dropped
    for (int k = 0; k < 4; k++) begin
      cyc(0, 0, 1, 32'hDEAD0000 + k);
      chk("R4 drop before set", out_valid, 0);
    end
    // R1 R2 stride sweep
    for (int s = 0; s < 16; s++) begin
      for (int w = 0; w < 4096; w += 1365) begin
        cyc(1, {16'hA5A5, 4'(s), 12'(w)}, 0, 0);
        chk("R1 set alone no output", out_valid, 0);
        model = 16'(w * 4);
        for (int k = 0; k < 3; k++) begin
          cyc(0, 0, 1, 32'(s * 100 + k));
          chk("R1 R2 addr", out_addr, model);
          chk("R5 data", out_data, 32'(s * 100 + k));
          chk("R5 valid", out_valid, 1);
          model = model + 16'(s * 4);
        end
        cyc(0, 0, 0, 0);
        chk("R5 one-cycle pulse", out_valid, 0);
      end
    end
    // R6 set and emit together
    cyc(1, 32'h0000_3123, 1, 32'h55);
    chk("R6 same-cycle addr", out_addr, 16'h048C);
    cyc(0, 0, 1, 32'h56);
    chk("R6 same-cycle stride", out_addr, 16'h048C + 16'd12);
    // R3 wrap
    cyc(1, 32'h0000_FFFF, 0, 0);
    model = 16'h3FFC;
    for (int k = 0; k < 900; k++) begin
      cyc(0, 0, 1, 32'(k));
      chk("R3 wrap addr", out_addr, model);
      model = model + 16'd60;
    end
    // R7 semaphore release
    cyc(1, {16'h0, 4'd1, SEM_BASE[13:2]}, 0, 0);
    cyc(0, 0, 1, 32'h0000_00AB);
    cyc(0, 0, 1, 32'hCDEF_0010);
    cyc(0, 0, 1, 32'h1234_5678);
    chk("R7 no early release", mem_valid, 0);
    cyc(0, 0, 1, KEY);
    chk("R7 mem_valid", mem_valid, 1);
    chk("R7 mem_addr", mem_addr, 64'h0000_00AB_CDEF_0010);
    chk("R7 mem_data", mem_data, 32'h1234_5678);
    cyc(0, 0, 0, 0);
    chk("R7 pulse ends", mem_valid, 0);
    // R8 wrong key
    cyc(1, {16'h0, 4'd3, SEM_BASE[13:2]}, 1, 32'h1);
    chk("R8 stride3 hits key slot next", out_addr, SEM_BASE);
    cyc(0, 0, 1, KEY + 1);
    chk("R8 out still written", out_addr, SEM_BASE + 16'd12);
    chk("R8 no release", mem_valid, 0);
    cyc(1, {16'h0, 4'd0, SEM_GO_W()}, 1, 32'h0);
    chk("R8 zero data no release", mem_valid, 0);
    // R9 scratch
    cyc(1, {16'h0, 4'd1, SCR_BASE[13:2]}, 0, 0);
    for (int i = 0; i < SCR_COUNT; i++) cyc(0, 0, 1, 32'hC0DE_0000 + i);
    cyc(0, 0, 1, 32'hFFFF_FFFF);
    for (int i = 0; i < SCR_COUNT; i++) begin
      rd_addr = SCR_BASE + 16'(4*i); #1;
      chk("R9 scratch read", rd_data, 32'hC0DE_0000 + i);
    end
    rd_addr = SCR_BASE - 16'd4; #1;
    chk("R9 below window", rd_data, 0);
    rd_addr = SCR_BASE + 16'(4*SCR_COUNT); #1;
    chk("R9 above window", rd_data, 0);
    rd_addr = SCR_BASE + 16'd2; #1;
    chk("R9 unaligned", rd_data, 0);
    // R4 reset clears flag
    do_reset();
    cyc(0, 0, 1, 32'h77);
    chk("R4 flag cleared by reset", out_valid, 0);
    rd_addr = SCR_BASE; #1;
    chk("R10 scratch cleared", rd_data, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  function automatic logic [11:0] SEM_GO_W();
    logic [15:0] a;
    a = SEM_BASE + 16'd12;
    return a[13:2];
  endfunction
endmodule